// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block watches the write cycles that a host issues to a parallel flash-style device and turns recognised command sequences into single-cycle operation requests for the engine that does the real work. Program and erase commands must be preceded by unlock writes, which protects against stray writes. A page program needs a three-write sequence: one unlock pair, then the program code. Chip and sector erase need six writes: an unlock pair, a setup code, a second unlock pair, then the erase code. For a sector erase, the top address bits of the last write select the sector.

The block also keeps the read mode for the data path, which is either array data or the status register. Every program or erase request, and every read-status command, switches reads to status. Reads stay in status until a read-array command is written. While the engine reports busy, program and erase sequences are refused. The two single-write read commands are still accepted during that time.

Each write is modelled as a one-clock strobe. Address and data are captured on the same edge. The write interface has no back-pressure: every strobed cycle is consumed and cannot be stalled. The request outputs are plain one-cycle pulses with no acknowledge.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all five request outputs are low, `rd_mode_status` is 0 (array reads) and `sect_sel` is 0.
- R2: The writes AAh at address 555h, then 55h at address 2AAh, then A0h (any address) make `req_prog` high for exactly the one cycle after the clock edge that captures the third write. Unlock addresses must match on all address bits.
- R3: The six writes AAh@555h, 55h@2AAh, 80h, AAh@555h, 55h@2AAh, 10h produce a one-cycle `req_chip_erase` pulse, timed as in R2.
- R4: The same six-write form ending in 30h produces a one-cycle `req_sect_erase`. On the same edge, `sect_sel` takes address bits [19:16] of that last write. `sect_sel` changes only together with a sector request.
- R5: At the third write, any data other than A0h or 80h produces no request and returns the sequence to idle. At the sixth write, any data other than 10h or 30h does the same.
- R6: A wrong address or wrong data on any unlock write, or on the setup write, returns the sequence to idle and produces no request.
- R7: A single write of 70h from idle pulses `req_rd_status`. One cycle after that pulse, `rd_mode_status` is 1.
- R8: A single write of F0h from idle pulses `req_rd_array`. One cycle after that pulse, `rd_mode_status` is 0.
- R9: One cycle after a program or erase request, `rd_mode_status` is 1. It stays 1 across the busy period and after busy falls, until R8 clears it.
- R10: While `busy` is high, no program or erase request is issued and any partly entered sequence is dropped. The R7 and R8 commands are still accepted.
- R11: Cycles with `wr_stb` low neither advance nor reset the sequence and produce no request.
- R12: No two request outputs are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 8 | Write data / command code |
| busy | input | 1 | Operation engine is running |
| req_prog | output | 1 | Page program request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sect_erase | output | 1 | Sector erase request pulse |
| sect_sel | output | 4 | Sector index of the last sector erase |
| req_rd_status | output | 1 | Read-status command pulse |
| req_rd_array | output | 1 | Read-array command pulse |
| rd_mode_status | output | 1 | 1 = reads return status, 0 = array data |

## Verification
Every one of the 256 data codes is driven at the program decision point and again at the erase decision point. This shows that exactly A0h, 10h and 30h fire requests, and that 80h only advances the sequence. All 16 sector indices are driven with the sector code, which separates correct sector capture from a wrong slice or a failure to hold. A wrong address or data is injected at each unlock and setup position, and idle gaps are placed inside a sequence. Together these separate resetting on a mismatch from ignoring non-strobe cycles. Busy is raised before a sequence and also in the middle of one, which distinguishes refusing sequences while busy from refusing read commands.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0]  CODE_KEY_A   = 8'hAA;
  localparam logic [7:0]  CODE_KEY_B   = 8'h55;
  localparam logic [7:0]  CODE_PROG    = 8'hA0;
  localparam logic [7:0]  CODE_SETUP   = 8'h80;
  localparam logic [7:0]  CODE_CHIP    = 8'h10;
  localparam logic [7:0]  CODE_SECT    = 8'h30;
  localparam logic [7:0]  CODE_STATUS  = 8'h70;
  localparam logic [7:0]  CODE_ARRAY   = 8'hF0;
  localparam logic [11:0] KEY_A_ADDR   = 12'h555;
  localparam logic [11:0] KEY_B_ADDR   = 12'h2AA;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_SETUP,
    ST_KEY3,
    ST_KEY4
  } seq_step_e;
endpackage

// File: rtl/flash_unlock_match.sv
module flash_unlock_match
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              key_a_hit,
  output logic              key_b_hit
);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(KEY_A_ADDR);
  localparam logic [ADDR_W-1:0] B_ADDR = ADDR_W'(KEY_B_ADDR);
  localparam logic [DATA_W-1:0] A_DATA = DATA_W'(CODE_KEY_A);
  localparam logic [DATA_W-1:0] B_DATA = DATA_W'(CODE_KEY_B);

  always_comb begin
    key_a_hit = (addr == A_ADDR) && (data == A_DATA);
    key_b_hit = (addr == B_ADDR) && (data == B_DATA);
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SECT_W-1:0] sect_field,
  input  logic              busy,
  input  logic              key_a_hit,
  input  logic              key_b_hit,
  output logic              req_prog,
  output logic              req_chip,
  output logic              req_sect,
  output logic              req_status,
  output logic              req_array,
  output logic [SECT_W-1:0] sect_sel
);
  localparam logic [DATA_W-1:0] D_PROG   = DATA_W'(CODE_PROG);
  localparam logic [DATA_W-1:0] D_SETUP  = DATA_W'(CODE_SETUP);
  localparam logic [DATA_W-1:0] D_CHIP   = DATA_W'(CODE_CHIP);
  localparam logic [DATA_W-1:0] D_SECT   = DATA_W'(CODE_SECT);
  localparam logic [DATA_W-1:0] D_STATUS = DATA_W'(CODE_STATUS);
  localparam logic [DATA_W-1:0] D_ARRAY  = DATA_W'(CODE_ARRAY);

  seq_step_e step_q, step_d;
  logic hit_prog, hit_chip, hit_sect, hit_status, hit_array;

  always_comb begin
    step_d     = step_q;
    hit_prog   = 1'b0;
    hit_chip   = 1'b0;
    hit_sect   = 1'b0;
    hit_status = 1'b0;
    hit_array  = 1'b0;
    if (wr_stb) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE: begin
          if (key_a_hit)              step_d = ST_KEY1;
          else if (wr_data == D_STATUS) hit_status = 1'b1;
          else if (wr_data == D_ARRAY)  hit_array  = 1'b1;
        end
        ST_KEY1:  if (key_b_hit) step_d = ST_KEY2;
        ST_KEY2: begin
          if (wr_data == D_PROG)       hit_prog = 1'b1;
          else if (wr_data == D_SETUP) step_d   = ST_SETUP;
        end
        ST_SETUP: if (key_a_hit) step_d = ST_KEY3;
        ST_KEY3:  if (key_b_hit) step_d = ST_KEY4;
        ST_KEY4: begin
          if (wr_data == D_CHIP)      hit_chip = 1'b1;
          else if (wr_data == D_SECT) hit_sect = 1'b1;
        end
        default: step_d = ST_IDLE;
      endcase
    end
    if (busy) begin
      step_d   = ST_IDLE;
      hit_prog = 1'b0;
      hit_chip = 1'b0;
      hit_sect = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q     <= ST_IDLE;
      req_prog   <= 1'b0;
      req_chip   <= 1'b0;
      req_sect   <= 1'b0;
      req_status <= 1'b0;
      req_array  <= 1'b0;
      sect_sel   <= '0;
    end else begin
      step_q     <= step_d;
      req_prog   <= hit_prog;
      req_chip   <= hit_chip;
      req_sect   <= hit_sect;
      req_status <= hit_status;
      req_array  <= hit_array;
      if (hit_sect) sect_sel <= sect_field;
    end
  end

  // R12
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_prog, req_chip, req_sect, req_status, req_array}));

  // R2
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |=> !req_prog);

  // R2
  prog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |-> ($past(wr_stb) && $past(wr_data) == D_PROG));

  // R3
  chip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_chip |-> ($past(wr_stb) && $past(wr_data) == D_CHIP));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(req_prog || req_chip || req_sect));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !(req_prog || req_chip || req_sect || req_status || req_array));
endmodule

// File: rtl/flash_read_mode.sv
module flash_read_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic set_status,
  input  logic set_array,
  output logic mode_status
);
  always_ff @(posedge clk) begin
    if (!rst_n)          mode_status <= 1'b0;
    else if (set_status) mode_status <= 1'b1;
    else if (set_array)  mode_status <= 1'b0;
  end

  // R8
  array_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_array |=> !mode_status);

  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_status |=> mode_status);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_status || set_array) |=> $stable(mode_status));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              req_prog,
  output logic              req_chip_erase,
  output logic              req_sect_erase,
  output logic [SECT_W-1:0] sect_sel,
  output logic              req_rd_status,
  output logic              req_rd_array,
  output logic              rd_mode_status
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic key_a_hit, key_b_hit;
  logic any_status;

  flash_unlock_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr      (wr_addr),
    .data      (wr_data),
    .key_a_hit (key_a_hit),
    .key_b_hit (key_b_hit)
  );

  flash_seq_fsm #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .sect_field (wr_addr[SECT_LSB +: SECT_W]),
    .busy       (busy),
    .key_a_hit  (key_a_hit),
    .key_b_hit  (key_b_hit),
    .req_prog   (req_prog),
    .req_chip   (req_chip_erase),
    .req_sect   (req_sect_erase),
    .req_status (req_rd_status),
    .req_array  (req_rd_array),
    .sect_sel   (sect_sel)
  );

  assign any_status = req_prog | req_chip_erase | req_sect_erase | req_rd_status;

  flash_read_mode u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_status  (any_status),
    .set_array   (req_rd_array),
    .mode_status (rd_mode_status)
  );

  // R4
  sect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sect_sel != $past(sect_sel)) |-> req_sect_erase);
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        req_prog, req_chip_erase, req_sect_erase, req_rd_status, req_rd_array;
  logic        rd_mode_status;
  logic [3:0]  sect_sel;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  // request vector encoding: {prog, chip, sect, status, array}
  localparam int P = 16, C = 8, S = 4, RS = 2, RA = 1;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .req_prog(req_prog), .req_chip_erase(req_chip_erase),
    .req_sect_erase(req_sect_erase), .sect_sel(sect_sel), .req_rd_status(req_rd_status),
    .req_rd_array(req_rd_array), .rd_mode_status(rd_mode_status)
  );

  function automatic int reqs();
    return {27'd0, req_prog, req_chip_erase, req_sect_erase, req_rd_status, req_rd_array};
  endfunction

  task automatic chk(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_addr = 20'h555; wr_data = 8'h70;
    end
  endtask

  task automatic unlock();
    wr(20'h555, 8'hAA);
    wr(20'h2AA, 8'h55);
  endtask

  task automatic to_array();
    wr(20'h0, 8'hF0);
    gap(1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reqs", reqs(), 0);
    chk("R1 mode", int'(rd_mode_status), 0);
    chk("R1 sect", int'(sect_sel), 0);

    // R2 R5: every code at the program decision point
    for (int d = 0; d < 256; d++) begin
      unlock();
      wr(20'h555, 8'(d));
      chk("R2/R5 third-write code", reqs(), (d == 8'hA0) ? P : 0);
      wr(20'h0, 8'h00);
      chk("R12/R5 after third write", reqs(), 0);
      if (d == 8'hA0) begin
        gap(1);
        chk("R9 mode after program", int'(rd_mode_status), 1);
        to_array();
        chk("R8 mode array", int'(rd_mode_status), 0);
      end
    end

    // R3 R4 R5: every code at the erase decision point
    for (int d = 0; d < 256; d++) begin
      unlock();
      wr(20'h555, 8'h80);
      unlock();
      wr(20'h30000, 8'(d));
      chk("R3/R4/R5 sixth-write code", reqs(),
          (d == 8'h10) ? C : (d == 8'h30) ? S : 0);
      gap(1);
      chk("R12 pulse width", reqs(), 0);
      chk("R9 mode after erase", int'(rd_mode_status), (d == 8'h10 || d == 8'h30) ? 1 : 0);
      to_array();
    end

    // R4: every sector index, then hold
    for (int s = 0; s < 16; s++) begin
      unlock();
      wr(20'h555, 8'h80);
      unlock();
      wr({4'(s), 16'h0123}, 8'h30);
      chk("R4 sector req", reqs(), S);
      chk("R4 sector index", int'(sect_sel), s);
      unlock();
      wr({4'(15 - s), 16'h0}, 8'hA0);
      chk("R2 program after sector", reqs(), P);
      chk("R4 sector held", int'(sect_sel), s);
      to_array();
    end

    // R6: corrupt each unlock/setup write
    for (int k = 0; k < 5; k++) begin
      logic [19:0] ad [6];
      logic [7:0]  dt [6];
      ad = '{20'h555, 20'h2AA, 20'h555, 20'h555, 20'h2AA, 20'h0};
      dt = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
      for (int m = 0; m < 2; m++) begin
        for (int j = 0; j < 6; j++) begin
          logic [19:0] a;
          logic [7:0]  d;
          a = ad[j]; d = dt[j];
          if (j == k) begin
            if (m == 0 && k != 2) a = a ^ 20'h10000;
            else d = d ^ 8'h01;
          end
          wr(a, d);
          chk("R6 corrupted sequence", reqs(), 0);
        end
      end
    end

    // R11: idle gaps inside a sequence
    wr(20'h555, 8'hAA); gap(3);
    chk("R11 gap quiet", reqs(), 0);
    wr(20'h2AA, 8'h55); gap(2);
    wr(20'h0, 8'hA0);
    chk("R11 sequence survives gaps", reqs(), P);
    to_array();

    // R7 R8
    wr(20'h123, 8'h70);
    chk("R7 read status req", reqs(), RS);
    gap(1);
    chk("R7 mode status", int'(rd_mode_status), 1);
    wr(20'h0, 8'hF0);
    chk("R8 read array req", reqs(), RA);
    gap(1);
    chk("R8 mode array", int'(rd_mode_status), 0);

    // R10: busy blocks sequences but not reads
    busy = 1'b1;
    unlock();
    wr(20'h0, 8'hA0);
    chk("R10 program refused", reqs(), 0);
    unlock();
    wr(20'h555, 8'h80);
    unlock();
    wr(20'h0, 8'h10);
    chk("R10 erase refused", reqs(), 0);
    wr(20'h0, 8'h70);
    chk("R10 status while busy", reqs(), RS);
    wr(20'h0, 8'hF0);
    chk("R10 array while busy", reqs(), RA);
    busy = 1'b0;
    unlock();
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    wr(20'h0, 8'hA0);
    chk("R10 partial sequence dropped", reqs(), 0);

    // R9: status mode survives busy
    unlock();
    wr(20'h0, 8'hA0);
    chk("R9 program req", reqs(), P);
    busy = 1'b1; gap(5); busy = 1'b0; gap(3);
    chk("R9 status held after busy", int'(rd_mode_status), 1);
    wr(20'h0, 8'h70); gap(1);
    chk("R9 status still", int'(rd_mode_status), 1);
    to_array();
    chk("R9 cleared by array", int'(rd_mode_status), 0);

    finish_run();
  end
endmodule